// File: doc/BRIEF.md
# Five-Bit XNOR Pseudo-Random Sequence Generator

This block produces a repeating pseudo-random pattern from a chain of five one-bit registers. On every enabled rising clock edge each stage passes its bit one place up the chain. The lowest stage takes a feedback bit, which is the inverted exclusive-OR of stages 1 and 4. With this inverted feedback the all-zeros word is an ordinary member of the sequence, so a plain synchronous reset is all the block needs to start. The all-ones word is the one value the sequence never reaches.

All five register bits are driven out in parallel on every cycle. A caller may also load a chosen seed. The block raises a flag during any cycle in which the seed offered is the all-ones lock-up word, because once the chain holds that word it stays there.

Top module: `lfsr5_xnor_gen`

## Requirements
- R1: When `rst` is high at a rising edge, `state_o` is 5'b00000 after that edge, whatever `seed_load` and `en` are doing.
- R2: When `rst` and `seed_load` are low and `en` is high, the next state puts the old bit k into bit k+1 for k = 0..3, and sets bit 0 to 1 when old bits 1 and 4 are equal and to 0 when they differ.
- R3: When `rst`, `seed_load` and `en` are all low, `state_o` keeps its value across the edge.
- R4: When `seed_load` is high and `rst` is low, `state_o` equals `seed_val` after the edge, whether `en` is high or low.
- R5: `seed_err_o` is high in the same cycle exactly when `seed_load` is high and `seed_val` is 5'b11111. Otherwise it is low.
- R6: Once `state_o` is 5'b11111, enabled stepping leaves it at 5'b11111.
- R7: Starting from reset and with `en` held high, the next 31 states are all different. None of them is 5'b11111, none of the first 30 is 5'b00000, and the 31st is 5'b00000 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the chain |
| en | input | 1 | Step enable; the chain holds when low |
| seed_load | input | 1 | Loads `seed_val`; takes priority over stepping |
| seed_val | input | 5 | Seed word written on a load |
| state_o | output | 5 | All five register bits, bit 0 being the feedback stage |
| seed_err_o | output | 1 | High while a load offers the lock-up word |

## Verification
A seed load and a step request can arrive on the same edge, and so can a reset and a load. The bench provokes both cases by driving `seed_load`, `en` and `rst` high together on chosen cycles. The scoreboard then expects the load to win over stepping, and the reset to win over the load. Each case is judged against an independent next-state model, and the error flag is sampled in the same cycle as the load that raises it.

// File: rtl/lfsr5_pkg.sv
package lfsr5_pkg;
  localparam int unsigned LFSR_W = 5;
  localparam int unsigned TAP_LO = 1;
  localparam int unsigned TAP_HI = 4;

  typedef logic [LFSR_W-1:0] lfsr_t;

  localparam lfsr_t LOCKUP_VAL = '1;
  localparam lfsr_t CLEAR_VAL  = '0;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // Inverted parity of the two tap stages
  function automatic logic fb_bit(input lfsr_t s);
    return ~(s[TAP_LO] ^ s[TAP_HI]);
  endfunction

  function automatic logic is_lockup(input lfsr_t s);
    return s == LOCKUP_VAL;
  endfunction
endpackage

// File: rtl/lfsr5_ctrl.sv
module lfsr5_ctrl
  import lfsr5_pkg::*;
(
  input  logic  rst,
  input  logic  en,
  input  logic  seed_load,
  input  lfsr_t seed_val,
  output op_e   op_o,
  output logic  seed_err_o
);
  always_comb begin
    if (rst)            op_o = OP_CLEAR;
    else if (seed_load) op_o = OP_LOAD;
    else if (en)        op_o = OP_SHIFT;
    else                op_o = OP_HOLD;
  end

  assign seed_err_o = seed_load & is_lockup(seed_val);
endmodule

// File: rtl/lfsr5_fb.sv
module lfsr5_fb
  import lfsr5_pkg::*;
(
  input  lfsr_t state_i,
  output logic  fb_o
);
  assign fb_o = fb_bit(state_i);
endmodule

// File: rtl/lfsr5_stage.sv
module lfsr5_stage
  import lfsr5_pkg::*;
#(
  parameter logic CLR_VAL = 1'b0
) (
  input  logic clk,
  input  op_e  op_i,
  input  logic shift_in,
  input  logic seed_in,
  output logic q
);
  always_ff @(posedge clk) begin
    unique case (op_i)
      OP_CLEAR: q <= CLR_VAL;
      OP_LOAD:  q <= seed_in;
      OP_SHIFT: q <= shift_in;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/lfsr5_xnor_gen.sv
module lfsr5_xnor_gen
  import lfsr5_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_val,
  output logic [LFSR_W-1:0] state_o,
  output logic              seed_err_o
);
  op_e   op_w;
  logic  fb_w;
  lfsr_t chain_w;

  lfsr5_ctrl ctrl_i (
    .rst       (rst),
    .en        (en),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .op_o      (op_w),
    .seed_err_o(seed_err_o)
  );

  lfsr5_fb fb_i (
    .state_i(chain_w),
    .fb_o   (fb_w)
  );

  for (genvar k = 0; k < LFSR_W; k++) begin : g_stage
    logic src_w;
    if (k == 0) begin : g_head
      assign src_w = fb_w;
    end else begin : g_body
      assign src_w = chain_w[k-1];
    end
    lfsr5_stage #(.CLR_VAL(CLEAR_VAL[k])) stage_i (
      .clk     (clk),
      .op_i    (op_w),
      .shift_in(src_w),
      .seed_in (seed_val[k]),
      .q       (chain_w[k])
    );
  end

  assign state_o = chain_w;
endmodule

// File: rtl/lfsr5_chk.sv
module lfsr5_chk
  import lfsr5_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        seed_load,
  input logic [4:0]  seed_val,
  input logic [4:0]  state_o,
  input logic        seed_err_o
);
  logic armed_q = 1'b0;
  always_ff @(posedge clk) if (rst) armed_q <= 1'b1;

  // R1
  clear_on_reset_chk: assert property (@(posedge clk) disable iff (!armed_q)
    rst |=> state_o == 5'b00000);

  // R4
  seed_wins_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (!rst && seed_load) |=> state_o == $past(seed_val));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (!rst && !seed_load && !en) |=> $stable(state_o));

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (!rst && !seed_load && en) |=> state_o[4:1] == $past(state_o[3:0]));

  // R2
  feedback_in_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (!rst && !seed_load && en) |=>
      state_o[0] == ($past(state_o[1]) == $past(state_o[4])));

  // R5
  err_needs_load_chk: assert property (@(posedge clk) disable iff (!armed_q)
    seed_err_o |-> (seed_load && seed_val == 5'b11111));

  // R5
  err_raised_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (seed_load && seed_val == 5'b11111) |-> seed_err_o);

  // R6
  lockup_sticks_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (!rst && !seed_load && state_o == 5'b11111) |=> state_o == 5'b11111);
endmodule

bind lfsr5_xnor_gen lfsr5_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .seed_load (seed_load),
  .seed_val  (seed_val),
  .state_o   (state_o),
  .seed_err_o(seed_err_o)
);

// File: tb/lfsr5_xnor_gen_tb.sv
module lfsr5_xnor_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       seed_load = 1'b0;
  logic [4:0] seed_val = 5'd0;
  logic [4:0] state_o;
  logic       seed_err_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [4:0] mdl = 5'd0;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  lfsr5_xnor_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
    .seed_val(seed_val), .state_o(state_o), .seed_err_o(seed_err_o)
  );

  function automatic logic [4:0] model_next(logic [4:0] m, logic r, logic l,
                                            logic [4:0] s, logic e);
    logic [4:0] n;
    if (r) return 5'd0;
    if (l) return s;
    if (!e) return m;
    n[0] = (m[1] == m[4]);
    for (int i = 1; i < 5; i++) n[i] = m[i-1];
    return n;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(logic r, logic l, logic [4:0] s, logic e, string tag);
    item_t it;
    @(negedge clk);
    rst = r; seed_load = l; seed_val = s; en = e;
    #1;
    check("R5 seed_err_o", {4'd0, seed_err_o}, {4'd0, (l && s == 5'b11111)});
    mdl = model_next(mdl, r, l, s, e);
    it.exp = mdl; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares the state produced by each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, state_o, it.exp);
    end
  end

  initial begin
    logic [4:0] seen [0:31];
    bit         hit  [0:31];
    int         dup;
    // R1: reset wins over load and enable
    apply(1, 1, 5'h15, 1, "R1 reset over load");
    apply(1, 0, 5'h00, 1, "R1 reset");
    // R7 / R2: full period from reset
    for (int i = 0; i < 32; i++) hit[i] = 1'b0;
    dup = 0;
    for (int i = 0; i < 31; i++) begin
      apply(0, 0, 5'h00, 1, "R2 step");
      @(posedge clk); #3;
      seen[i] = state_o;
    end
    for (int i = 0; i < 31; i++) begin
      if (hit[seen[i]]) dup++;
      hit[seen[i]] = 1'b1;
    end
    check("R7 duplicate states", dup[4:0], 5'd0);
    check("R7 lock-up never reached", {4'd0, hit[31]}, 5'd0);
    check("R7 return to zero on step 31", seen[30], 5'd0);
    for (int i = 0; i < 30; i++)
      if (seen[i] == 5'd0) check("R7 early zero", seen[i], 5'h1);
    // R3: hold
    apply(0, 0, 5'h00, 1, "R2 step");
    apply(0, 0, 5'h00, 1, "R2 step");
    for (int i = 0; i < 3; i++) apply(0, 0, 5'h1b, 0, "R3 hold");
    // R4: load over step, and load while idle
    apply(0, 1, 5'h0a, 1, "R4 load with en");
    apply(0, 0, 5'h00, 1, "R2 step from seed");
    apply(0, 1, 5'h13, 0, "R4 load without en");
    for (int i = 0; i < 4; i++) apply(0, 0, 5'h00, 1, "R2 step from seed");
    // R5/R6: lock-up seed
    apply(0, 1, 5'h1f, 1, "R4 load lock-up");
    for (int i = 0; i < 4; i++) apply(0, 0, 5'h00, 1, "R6 lock-up stays");
    // R1: reset escapes lock-up
    apply(1, 1, 5'h1f, 1, "R1 reset over lock-up load");
    apply(0, 0, 5'h00, 1, "R2 step after reset");
    apply(0, 0, 5'h00, 0, "R3 hold");
    @(posedge clk); #5;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule